// File: doc/BRIEF.md
# Scan-testable reversible master-slave D register

This block is a WIDTH-bit edge-triggered D register. Each bit is two level-sensitive latches in series, and every latch is built only from reversible gate primitives. The primitives are a controlled swap, a controlled-controlled inverter and a plain inverter. The first latch (the leader) is open while `clk` is high. The second latch (the follower) is open while `clk` is low. The register therefore takes `d` on the falling edge of `clk`.

Each latch has its own pair of mode inputs. These decide what goes back on the latch's hold path. Normal mode returns the stored bit. The two test modes force the hold path to a constant 0 or a constant 1. Forcing the hold path opens the storage loop, so the register can be tested for stuck-at-1 faults with an all-zeros vector and for stuck-at-0 faults with an all-ones vector. The forced or stored value on each hold path is visible on the `m_tap` and `s_tap` outputs. The outputs the gates do not use are gathered on `garb`.

A parameter chooses how the hold/pass selector in each latch is built: from a single controlled swap, or from two controlled-controlled inverters and an inverter. Both choices have the same behaviour at the ports.

Top module: `rev_msff`

## Requirements
- R1: With both mode pairs at {c1,c2} = {0,1}, `q` takes the value `d` had at a falling edge of `clk`. It holds that value until the next falling edge, even if `d` changes in between.
- R2: With the leader in normal mode, `m_tap` follows `d` while `clk` is high. While `clk` is low it keeps the value `d` had at the falling edge.
- R3: With the follower in normal mode, `s_tap` follows `m_tap` while `clk` is low. While `clk` is high it keeps the value it had at the rising edge.
- R4: A latch whose mode pair is {0,0} drives its tap to all zeros for every `d` and every clock phase. With both latches in this mode, `q` is all zeros.
- R5: A latch whose mode pair is {1,1} drives its tap to all ones for every `d` and every clock phase. With both latches in this mode, `q` is all ones.
- R6: In every mode, `q` equals `m_tap` while `clk` is low and equals `s_tap` while `clk` is high.
- R7: The mode pair {c1,c2} = {1,0} behaves like {0,0}: the tap of that latch is all zeros.
- R8: Mode changes do not alter a latch's stored bit. When a holding latch is switched into a test mode and back to normal, its tap shows the value it held before.
- R9: Each gate primitive is a bijection on its inputs. The controlled swap exchanges inputs a and b when c is 1. The controlled-controlled inverter flips c when a and b are both 1. Both pass their control inputs through unchanged.
- R10: The two selector variants produce the same `q`, `m_tap` and `s_tap` for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; leader open when high, follower open when low |
| d | input | WIDTH | Data in |
| m_c1 | input | 1 | Leader mode bit 1 |
| m_c2 | input | 1 | Leader mode bit 2 |
| s_c1 | input | 1 | Follower mode bit 1 |
| s_c2 | input | 1 | Follower mode bit 2 |
| q | output | WIDTH | Register output |
| m_tap | output | WIDTH | Leader hold-path tap |
| s_tap | output | WIDTH | Follower hold-path tap |
| garb | output | 2*WIDTH*(4+mux_garb(MUX_STYLE)) | Unused gate outputs |

## Verification
The checker looks at every clock edge and confirms four things. The taps take their forced constants in the test modes, including the reserved code. `q` is the follower's tap in one clock phase and the leader's tap in the other. The leader tracks `d` while open, and the follower tracks the leader. Some behaviour needs values held across an edge or across a mode change, and only the bench scenarios can show it. That covers capture on the falling edge and holding through the next whole cycle, a stored bit coming back after a test mode, agreement between the two selector variants, and the exhaustive bijection check of each primitive.

// File: rtl/rmsff_pkg.sv
package rmsff_pkg;
   localparam int unsigned MUX_SWAP  = 0;
   localparam int unsigned MUX_CCNOT = 1;
   localparam int unsigned TAP_GARB  = 4;

   function automatic int unsigned mux_garb(input int unsigned style);
      return (style == MUX_CCNOT) ? 4 : 2;
   endfunction
endpackage

// File: rtl/rv_not.sv
module rv_not (
   input  logic a,
   output logic y
);
   assign y = ~a;
endmodule

// File: rtl/rv_fredkin.sv
module rv_fredkin (
   input  logic c,
   input  logic a,
   input  logic b,
   output logic p,
   output logic q,
   output logic r
);
   assign p = c;
   assign q = c ? b : a;
   assign r = c ? a : b;
endmodule

// File: rtl/rv_toffoli.sv
module rv_toffoli (
   input  logic a,
   input  logic b,
   input  logic c,
   output logic p,
   output logic q,
   output logic r
);
   assign p = a;
   assign q = b;
   assign r = c ^ (a & b);
endmodule

// File: rtl/rv_latch.sv
module rv_latch
   import rmsff_pkg::*;
#(
   parameter int unsigned MUX_STYLE = MUX_SWAP,
   parameter bit          OPEN_HIGH = 1'b1,
   localparam int unsigned GW       = TAP_GARB + mux_garb(MUX_STYLE)
) (
   input  logic          d,
   input  logic          en,
   input  logic          c1,
   input  logic          c2,
   output logic          y,
   output logic          tap,
   output logic [GW-1:0] garb
);
   logic en_eff;
   logic st;
   logic st_or;

   generate
      if (OPEN_HIGH) begin : g_pol_hi
         assign en_eff = en;
      end else begin : g_pol_lo
         rv_not u_inv (.a(en), .y(en_eff));
      end
   endgenerate

   always_latch begin
      if (en_eff) st <= d;
   end

   // hold path: tap = c2 & (st | c1)
   rv_fredkin u_or (
      .c(c1), .a(st), .b(1'b1),
      .p(garb[0]), .q(st_or), .r(garb[1])
   );
   rv_toffoli u_and (
      .a(c2), .b(st_or), .c(1'b0),
      .p(garb[2]), .q(garb[3]), .r(tap)
   );

   // pass/hold selector: y = en_eff ? d : tap
   generate
      if (MUX_STYLE == MUX_CCNOT) begin : g_mux_ccnot
         logic pass_t;
         logic en_n;
         rv_toffoli u_pass (
            .a(en_eff), .b(d), .c(1'b0),
            .p(garb[4]), .q(garb[5]), .r(pass_t)
         );
         rv_not u_ninv (.a(en_eff), .y(en_n));
         rv_toffoli u_hold (
            .a(en_n), .b(tap), .c(pass_t),
            .p(garb[6]), .q(garb[7]), .r(y)
         );
      end else begin : g_mux_swap
         rv_fredkin u_sel (
            .c(en_eff), .a(tap), .b(d),
            .p(garb[4]), .q(y), .r(garb[5])
         );
      end
   endgenerate
endmodule

// File: rtl/rev_msff.sv
module rev_msff
   import rmsff_pkg::*;
#(
   parameter int unsigned WIDTH     = 4,
   parameter int unsigned MUX_STYLE = MUX_SWAP
) (
   input  logic                                             clk,
   input  logic [WIDTH-1:0]                                 d,
   input  logic                                             m_c1,
   input  logic                                             m_c2,
   input  logic                                             s_c1,
   input  logic                                             s_c2,
   output logic [WIDTH-1:0]                                 q,
   output logic [WIDTH-1:0]                                 m_tap,
   output logic [WIDTH-1:0]                                 s_tap,
   output logic [2*WIDTH*(TAP_GARB+mux_garb(MUX_STYLE))-1:0] garb
);
   localparam int unsigned LGW = TAP_GARB + mux_garb(MUX_STYLE);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("rev_msff: WIDTH must be at least 1");
      end
      if (MUX_STYLE > MUX_CCNOT) begin : g_bad_style
         $error("rev_msff: unknown MUX_STYLE");
      end
   endgenerate

   logic [WIDTH-1:0] lead_y;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         rv_latch #(.MUX_STYLE(MUX_STYLE), .OPEN_HIGH(1'b1)) u_lead (
            .d(d[b]), .en(clk), .c1(m_c1), .c2(m_c2),
            .y(lead_y[b]), .tap(m_tap[b]),
            .garb(garb[(2*b)*LGW +: LGW])
         );
         rv_latch #(.MUX_STYLE(MUX_STYLE), .OPEN_HIGH(1'b0)) u_foll (
            .d(lead_y[b]), .en(clk), .c1(s_c1), .c2(s_c2),
            .y(q[b]), .tap(s_tap[b]),
            .garb(garb[(2*b+1)*LGW +: LGW])
         );
      end
   endgenerate
endmodule

// File: rtl/rev_msff_chk.sv
module rev_msff_chk #(
   parameter int unsigned WIDTH = 4
) (
   input logic             clk,
   input logic [WIDTH-1:0] d,
   input logic             m_c1,
   input logic             m_c2,
   input logic             s_c1,
   input logic             s_c2,
   input logic [WIDTH-1:0] q,
   input logic [WIDTH-1:0] m_tap,
   input logic [WIDTH-1:0] s_tap
);
   // R2
   lead_track_chk: assert property (@(negedge clk)
      (!m_c1 && m_c2) |-> (m_tap == d));
   // R3
   foll_track_chk: assert property (@(posedge clk)
      (!s_c1 && s_c2) |-> (s_tap == m_tap));
   // R4
   lead_zero_chk: assert property (@(negedge clk)
      (!m_c1 && !m_c2) |-> (m_tap == '0));
   // R4
   foll_zero_chk: assert property (@(posedge clk)
      (!s_c1 && !s_c2) |-> (s_tap == '0));
   // R5
   lead_ones_chk: assert property (@(posedge clk)
      (m_c1 && m_c2) |-> (m_tap == '1));
   // R5
   foll_ones_chk: assert property (@(negedge clk)
      (s_c1 && s_c2) |-> (s_tap == '1));
   // R6
   q_low_chk: assert property (@(posedge clk) q == m_tap);
   // R6
   q_high_chk: assert property (@(negedge clk) q == s_tap);
   // R7
   lead_rsvd_chk: assert property (@(posedge clk)
      (m_c1 && !m_c2) |-> (m_tap == '0));
   // R7
   foll_rsvd_chk: assert property (@(negedge clk)
      (s_c1 && !s_c2) |-> (s_tap == '0));
endmodule

bind rev_msff rev_msff_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_rev_msff.sv
module tb_rev_msff;
   import rmsff_pkg::*;
   localparam int  W     = 4;
   localparam time CLK_P = 10;
   localparam int  GW0   = 2*W*(TAP_GARB+mux_garb(MUX_SWAP));
   localparam int  GW1   = 2*W*(TAP_GARB+mux_garb(MUX_CCNOT));

   logic clk = 1'b0;
   logic [W-1:0] d = '0;
   logic m_c1 = 1'b0, m_c2 = 1'b0, s_c1 = 1'b0, s_c2 = 1'b0;
   logic [W-1:0] q, m_tap, s_tap, q2, m_tap2, s_tap2;
   logic [GW0-1:0] garb;
   logic [GW1-1:0] garb2;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic [W-1:0] ref_q;
   bit ref_ok = 0;
   logic [7:0] lf = 8'h5A;

   always #(CLK_P/2) clk = ~clk;

   rev_msff #(.WIDTH(W), .MUX_STYLE(MUX_SWAP)) dut (
      .clk, .d, .m_c1, .m_c2, .s_c1, .s_c2,
      .q(q), .m_tap(m_tap), .s_tap(s_tap), .garb(garb));
   rev_msff #(.WIDTH(W), .MUX_STYLE(MUX_CCNOT)) dut_alt (
      .clk, .d, .m_c1, .m_c2, .s_c1, .s_c2,
      .q(q2), .m_tap(m_tap2), .s_tap(s_tap2), .garb(garb2));

   // primitive stimulus
   logic pa = 0, pb = 0, pc = 0;
   logic fp, fq, fr, tp, tq, tr;
   rv_fredkin u_fk (.c(pc), .a(pa), .b(pb), .p(fp), .q(fq), .r(fr));
   rv_toffoli u_tf (.a(pa), .b(pb), .c(pc), .p(tp), .q(tq), .r(tr));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      check(act === exp, req, int'(act), int'(exp));
   endtask

   task automatic alt_cmp();
      // R10: both selector variants agree
      cmp("R10 q", q2, q);
      cmp("R10 m_tap", m_tap2, m_tap);
      cmp("R10 s_tap", s_tap2, s_tap);
   endtask

   task automatic set_modes(input logic [1:0] mm, input logic [1:0] sm);
      {m_c1, m_c2} = mm;
      {s_c1, s_c2} = sm;
   endtask

   function automatic logic [W-1:0] next_val();
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      return lf[W-1:0];
   endfunction

   task automatic ncycle(input logic [W-1:0] v);
      @(posedge clk); #1 d = v;
      #3;
      cmp("R2 lead open", m_tap, v);
      if (ref_ok) begin
         cmp("R1 hold high", q, ref_q);
         cmp("R3 foll hold", s_tap, ref_q);
      end
      alt_cmp();
      @(negedge clk);
      ref_q = v; ref_ok = 1;
      #2;
      cmp("R1 capture", q, v);
      cmp("R3 foll open", s_tap, v);
      cmp("R2 lead hold", m_tap, v);
      #1 d = ~v;
      #1;
      cmp("R2 lead ignores d", m_tap, v);
      cmp("R1 q ignores d", q, v);
      alt_cmp();
   endtask

   task automatic tcycle(input logic [W-1:0] v, input logic [W-1:0] e, input string req);
      @(posedge clk); #1 d = v;
      #3;
      cmp({req, " m_tap hi"}, m_tap, e);
      cmp({req, " s_tap hi"}, s_tap, e);
      cmp({req, " q hi"}, q, e);
      alt_cmp();
      @(negedge clk); #2;
      cmp({req, " m_tap lo"}, m_tap, e);
      cmp({req, " s_tap lo"}, s_tap, e);
      cmp({req, " q lo"}, q, e);
      alt_cmp();
   endtask

   initial begin
      #(CLK_P*5000);
      check(1'b0, "watchdog", 0, 1);
      if (!done) begin
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] seen;
      // R4: start-up in all-zeros test mode
      #2;
      cmp("R4 start m_tap", m_tap, '0);
      cmp("R4 start s_tap", s_tap, '0);
      cmp("R4 start q", q, '0);

      // R9: exhaustive primitive check
      seen = '0;
      for (int i = 0; i < 8; i++) begin
         {pc, pa, pb} = 3'(i);
         #1;
         check({fp, fq, fr} === {pc, (pc ? pb : pa), (pc ? pa : pb)},
               "R9 fredkin fn", int'({fp, fq, fr}), i);
         seen[{fp, fq, fr}] = 1'b1;
      end
      check(seen == 8'hFF, "R9 fredkin bijective", int'(seen), 255);
      seen = '0;
      for (int i = 0; i < 8; i++) begin
         {pa, pb, pc} = 3'(i);
         #1;
         check({tp, tq, tr} === {pa, pb, pc ^ (pa & pb)},
               "R9 toffoli fn", int'({tp, tq, tr}), i);
         seen[{tp, tq, tr}] = 1'b1;
      end
      check(seen == 8'hFF, "R9 toffoli bijective", int'(seen), 255);

      // R1 R2 R3: normal operation
      set_modes(2'b01, 2'b01);
      ref_ok = 0;
      ncycle(4'hA);
      ncycle(4'h5);
      ncycle(4'hF);
      ncycle(4'h0);
      for (int k = 0; k < 10; k++) ncycle(next_val());

      // R8: stored bit survives a test-mode excursion (leader, clk low)
      ncycle(4'h6);
      @(posedge clk); #1 d = 4'h9;
      @(negedge clk); #1;
      set_modes(2'b11, 2'b01);
      #1 cmp("R8 lead forced", m_tap, '1);
      cmp("R8 q forced low", q, '1);
      set_modes(2'b01, 2'b01);
      #1 cmp("R8 lead restored", m_tap, 4'h9);
      cmp("R8 q restored", q, 4'h9);
      // R8: follower excursion during clk high
      @(posedge clk); #2;
      set_modes(2'b01, 2'b00);
      #1 cmp("R8 foll forced", s_tap, '0);
      cmp("R6 q tracks s_tap", q, '0);
      set_modes(2'b01, 2'b01);
      #1 cmp("R8 foll restored", s_tap, 4'h9);
      cmp("R8 q back", q, 4'h9);

      // R4: all-zeros test mode
      set_modes(2'b00, 2'b00);
      tcycle(4'h0, 4'h0, "R4");
      tcycle(4'hF, 4'h0, "R4");
      tcycle(4'h3, 4'h0, "R4");
      // R5: all-ones test mode
      set_modes(2'b11, 2'b11);
      tcycle(4'hF, 4'hF, "R5");
      tcycle(4'h0, 4'hF, "R5");
      tcycle(4'hC, 4'hF, "R5");
      // R7: reserved code acts as zeros
      set_modes(2'b10, 2'b10);
      tcycle(4'hF, 4'h0, "R7");
      tcycle(4'h5, 4'h0, "R7");

      // R6: mixed modes, leader normal and follower forced to ones
      set_modes(2'b01, 2'b11);
      @(posedge clk); #1 d = 4'h3;
      #3 cmp("R6 q high = s_tap", q, 4'hF);
      @(negedge clk); #2 cmp("R6 q low = m_tap", q, 4'h3);

      // back to normal
      set_modes(2'b01, 2'b01);
      ref_ok = 0;
      ncycle(4'h7);
      ncycle(4'h8);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule